// File: doc/BRIEF.md
# Dual-Polarity HDLC Bit Stuffer and Destuffer

This block keeps a serial HDLC-style line free of long edge-less stretches. Its transmit half takes payload bits one per clock through a valid/ready handshake. After five logical ones in a row it adds a zero. When one-insertion is active, it also adds a one after seven logical zeros in a row, so that a clock-recovery loop at the far end keeps seeing transitions. Bits tagged as flag or abort on a bypass input go out untouched. Its receive half takes line bits, removes both kinds of added bits, and passes the remaining frame bits on. When it sees six ones in a row, it raises a flag/abort pulse instead of passing the bit.

Three static inputs set the mode. Bus mode selects the bus configuration, which always uses NRZ coding. One-insertion takes effect only in bus mode. Line inversion takes effect only outside bus mode, and maps a logical one to a low line level and a logical zero to a high one, on both line pins.

Top module: `hdlc_transparency_coder`

## Requirements
- R1: After five consecutive stuffable logical ones on the transmit line, the next line bit is a zero that was not taken from the payload, so no stuffed stream has more than five ones in a row.
- R2: With `cfg_one_ins_i` and `cfg_bus_mode_i` both high, after seven consecutive logical zeros the next transmit line bit is an added one. If either input is low, no one is ever added (twenty payload zeros leave as twenty line zeros).
- R3: An added bit counts as the first bit of the opposite run. For payload 11111 followed by 000000, with one-insertion active, the line carries 11111 0 000000 1.
- R4: Each line bit leaves one clock after the transmit state that produced it, at one bit per clock. `tx_ready_o` is low in every cycle in which an added bit is being emitted, and the number of stalled cycles equals the number of bits added while payload is pending.
- R5: A payload bit with `tx_raw_i` high is sent unchanged, is never followed by an added bit on its account, and clears both transmit run counters.
- R6: The receiver drops a zero that follows five ones. With one-insertion active it also drops a one that follows seven zeros. Every other bit appears on `rx_bit_o` with `rx_valid_o` one clock after it is accepted, so transmit looped into receive returns the payload exactly.
- R7: A one received after five ones is not passed on. `rx_flag_o` pulses for one clock instead, never together with `rx_valid_o`, and both receive run counters clear.
- R8: With `cfg_invert_i` high and `cfg_bus_mode_i` low, `line_tx_o` is the inverse of the logical bit (logical 1 drives 0), and `line_rx_i` is inverted before destuffing.
- R9: With `cfg_bus_mode_i` high, `cfg_invert_i` has no effect on either line pin.
- R10: A synchronous reset (`srst_i` high at a clock edge) clears all four run counters and deasserts `line_tx_valid_o`, `rx_valid_o` and `rx_flag_o`. A run cut by the reset does not carry over into the bits that follow it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| srst_i | input | 1 | Synchronous reset, active high |
| cfg_bus_mode_i | input | 1 | Bus configuration (NRZ); enables one-insertion and disables inversion |
| cfg_one_ins_i | input | 1 | One-insertion enable, effective only in bus mode |
| cfg_invert_i | input | 1 | Line inversion enable, effective only outside bus mode |
| tx_bit_i | input | 1 | Payload bit |
| tx_valid_i | input | 1 | Payload bit valid |
| tx_raw_i | input | 1 | Payload bit is flag/abort, send without stuffing |
| tx_ready_o | output | 1 | Payload bit accepted at this edge when valid |
| line_tx_o | output | 1 | Transmit line level |
| line_tx_valid_o | output | 1 | Transmit line bit present this cycle |
| line_rx_i | input | 1 | Receive line level |
| line_rx_valid_i | input | 1 | Receive line bit present this cycle |
| rx_bit_o | output | 1 | Destuffed frame bit |
| rx_valid_o | output | 1 | Destuffed frame bit valid |
| rx_flag_o | output | 1 | Six-ones (flag/abort) indication pulse |

## Verification
The embedded properties watch, on every cycle, the local rules of the block. After a full ones counter the next transmit bit must be an added zero, and after a full zeros counter with one-insertion active it must be an added one. A refused payload bit must coincide with an emitted bit. The receiver must drop exactly the bits that follow a full counter, must pass every other bit through one cycle later, and must clear its counters with every flag pulse. The line pin polarity must follow the mode pins. Only the bench's scenarios can show the properties of whole streams: that looping transmit into receive returns random, all-zero and all-one payloads exactly, that the line never shows a forbidden run length, that bypassed flag bits reset the run history, and that a reset in the middle of a run leaves no trace in the bits that follow.

// File: rtl/hdlc_tc_pkg.sv
package hdlc_tc_pkg;

    // What the transmit register holds this cycle
    typedef enum logic [2:0] {
        TX_IDLE = 3'd0,
        TX_DATA = 3'd1,
        TX_RAW  = 3'd2,
        TX_INS0 = 3'd3,
        TX_INS1 = 3'd4
    } tx_kind_e;

    // What the receiver did with the last accepted line bit
    typedef enum logic [1:0] {
        RX_NONE = 2'd0,
        RX_PASS = 2'd1,
        RX_DROP = 2'd2,
        RX_FLAG = 2'd3
    } rx_kind_e;

    // Counter width able to hold the larger of the two run limits
    function automatic int run_cnt_width(input int ones_lim, input int zeros_lim);
        int top;
        top = (ones_lim > zeros_lim) ? ones_lim : zeros_lim;
        return $clog2(top + 1);
    endfunction

endpackage

// File: rtl/hdlc_tc_polarity.sv
module hdlc_tc_polarity #(
    parameter int WIDTH = 1
) (
    input  logic [WIDTH-1:0] bits_i,
    input  logic             invert_i,
    output logic [WIDTH-1:0] bits_o
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_lane
        assign bits_o[g] = bits_i[g] ^ invert_i;
    end

endmodule

// File: rtl/hdlc_tc_stuffer.sv
module hdlc_tc_stuffer
    import hdlc_tc_pkg::*;
#(
    parameter int ONES_LIMIT  = 5,
    parameter int ZEROS_LIMIT = 7
) (
    input  logic clk_i,
    input  logic srst_i,
    input  logic one_ins_i,
    input  logic in_bit_i,
    input  logic in_valid_i,
    input  logic in_raw_i,
    output logic in_ready_o,
    output logic out_bit_o,
    output logic out_valid_o
);

    localparam int              CNT_W     = run_cnt_width(ONES_LIMIT, ZEROS_LIMIT);
    localparam logic [CNT_W-1:0] ONES_TOP  = CNT_W'(ONES_LIMIT);
    localparam logic [CNT_W-1:0] ZEROS_TOP = CNT_W'(ZEROS_LIMIT);
    localparam logic [CNT_W-1:0] RUN_ONE   = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] ones;
        logic [CNT_W-1:0] zeros;
        logic             lbit;
        logic             valid;
        tx_kind_e         kind;
    } tx_st_t;

    tx_st_t st_d, st_q;
    logic   add_zero, add_one;

    function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v,
                                                 input logic [CNT_W-1:0] top);
        return (v >= top) ? top : v + RUN_ONE;
    endfunction

    always_comb begin
        add_zero    = (st_q.ones == ONES_TOP);
        add_one     = one_ins_i && (st_q.zeros == ZEROS_TOP);
        st_d        = st_q;
        st_d.valid  = 1'b0;
        st_d.kind   = TX_IDLE;
        if (add_zero) begin
            // added zero opens a zero run
            st_d.lbit  = 1'b0;
            st_d.valid = 1'b1;
            st_d.kind  = TX_INS0;
            st_d.ones  = '0;
            st_d.zeros = RUN_ONE;
        end else if (add_one) begin
            // added one opens a one run
            st_d.lbit  = 1'b1;
            st_d.valid = 1'b1;
            st_d.kind  = TX_INS1;
            st_d.zeros = '0;
            st_d.ones  = RUN_ONE;
        end else if (in_valid_i) begin
            st_d.lbit  = in_bit_i;
            st_d.valid = 1'b1;
            if (in_raw_i) begin
                st_d.kind  = TX_RAW;
                st_d.ones  = '0;
                st_d.zeros = '0;
            end else if (in_bit_i) begin
                st_d.kind  = TX_DATA;
                st_d.ones  = sat_inc(st_q.ones, ONES_TOP);
                st_d.zeros = '0;
            end else begin
                st_d.kind  = TX_DATA;
                st_d.zeros = sat_inc(st_q.zeros, ZEROS_TOP);
                st_d.ones  = '0;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (srst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign in_ready_o  = !(add_zero || add_one);
    assign out_bit_o   = st_q.lbit;
    assign out_valid_o = st_q.valid;

    // R1: a full ones run is followed by an added zero
    p_add_zero_r1: assert property (@(posedge clk_i) disable iff (srst_i)
        (st_q.ones == ONES_TOP) |=> (out_valid_o && !out_bit_o && st_q.kind == TX_INS0));

    // R1: the ones counter never passes its limit
    p_ones_bound_r1: assert property (@(posedge clk_i) disable iff (srst_i)
        st_q.ones <= ONES_TOP);

    // R2: a full zeros run with one-insertion active is followed by an added one
    p_add_one_r2: assert property (@(posedge clk_i) disable iff (srst_i)
        (one_ins_i && st_q.zeros == ZEROS_TOP) |=> (out_valid_o && out_bit_o && st_q.kind == TX_INS1));

    // R4: a refused payload bit always coincides with an emitted added bit
    p_stall_emits_r4: assert property (@(posedge clk_i) disable iff (srst_i)
        (in_valid_i && !in_ready_o) |=> (out_valid_o && st_q.kind != TX_DATA && st_q.kind != TX_RAW));

    // R4: an accepted payload bit leaves on the next cycle unchanged
    p_accept_out_r4: assert property (@(posedge clk_i) disable iff (srst_i)
        (in_valid_i && in_ready_o) |=> (out_valid_o && out_bit_o == $past(in_bit_i)));

    // R5: a bypassed bit leaves both run counters cleared
    p_raw_clear_r5: assert property (@(posedge clk_i) disable iff (srst_i)
        (in_valid_i && in_ready_o && in_raw_i) |=> (st_q.ones == '0 && st_q.zeros == '0));

    // R10: reset clears counters and output valid
    p_reset_tx_r10: assert property (@(posedge clk_i)
        srst_i |=> (!out_valid_o && st_q.ones == '0 && st_q.zeros == '0));

endmodule

// File: rtl/hdlc_tc_destuffer.sv
module hdlc_tc_destuffer
    import hdlc_tc_pkg::*;
#(
    parameter int ONES_LIMIT  = 5,
    parameter int ZEROS_LIMIT = 7
) (
    input  logic clk_i,
    input  logic srst_i,
    input  logic one_ins_i,
    input  logic in_bit_i,
    input  logic in_valid_i,
    output logic out_bit_o,
    output logic out_valid_o,
    output logic flag_o
);

    localparam int              CNT_W     = run_cnt_width(ONES_LIMIT, ZEROS_LIMIT);
    localparam logic [CNT_W-1:0] ONES_TOP  = CNT_W'(ONES_LIMIT);
    localparam logic [CNT_W-1:0] ZEROS_TOP = CNT_W'(ZEROS_LIMIT);
    localparam logic [CNT_W-1:0] RUN_ONE   = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] ones;
        logic [CNT_W-1:0] zeros;
        logic             lbit;
        logic             valid;
        logic             flag;
        rx_kind_e         kind;
    } rx_st_t;

    rx_st_t st_d, st_q;
    logic   ones_full, zeros_full;

    function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v,
                                                 input logic [CNT_W-1:0] top);
        return (v >= top) ? top : v + RUN_ONE;
    endfunction

    always_comb begin
        ones_full  = (st_q.ones == ONES_TOP);
        zeros_full = one_ins_i && (st_q.zeros == ZEROS_TOP);
        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.flag  = 1'b0;
        st_d.kind  = RX_NONE;
        if (in_valid_i) begin
            if (ones_full) begin
                if (in_bit_i) begin
                    // sixth one: flag or abort, not data
                    st_d.flag  = 1'b1;
                    st_d.kind  = RX_FLAG;
                    st_d.ones  = '0;
                    st_d.zeros = '0;
                end else begin
                    st_d.kind  = RX_DROP;
                    st_d.ones  = '0;
                    st_d.zeros = RUN_ONE;
                end
            end else if (zeros_full && in_bit_i) begin
                st_d.kind  = RX_DROP;
                st_d.zeros = '0;
                st_d.ones  = RUN_ONE;
            end else begin
                st_d.kind  = RX_PASS;
                st_d.valid = 1'b1;
                st_d.lbit  = in_bit_i;
                if (in_bit_i) begin
                    st_d.ones  = sat_inc(st_q.ones, ONES_TOP);
                    st_d.zeros = '0;
                end else begin
                    st_d.zeros = sat_inc(st_q.zeros, ZEROS_TOP);
                    st_d.ones  = '0;
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (srst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_bit_o   = st_q.lbit;
    assign out_valid_o = st_q.valid;
    assign flag_o      = st_q.flag;

    // R6: the zero after a full ones run is dropped
    p_drop_zero_r6: assert property (@(posedge clk_i) disable iff (srst_i)
        (in_valid_i && st_q.ones == ONES_TOP && !in_bit_i) |=> (!out_valid_o && !flag_o));

    // R6: the one after a full zeros run is dropped when one-insertion is active
    p_drop_one_r6: assert property (@(posedge clk_i) disable iff (srst_i)
        (in_valid_i && one_ins_i && st_q.zeros == ZEROS_TOP && in_bit_i) |=> !out_valid_o);

    // R6: ordinary bits pass one cycle later unchanged
    p_pass_r6: assert property (@(posedge clk_i) disable iff (srst_i)
        (in_valid_i && st_q.ones != ONES_TOP && !(one_ins_i && st_q.zeros == ZEROS_TOP))
        |=> (out_valid_o && out_bit_o == $past(in_bit_i)));

    // R7: a sixth one raises the flag and clears the counters
    p_flag_r7: assert property (@(posedge clk_i) disable iff (srst_i)
        (in_valid_i && st_q.ones == ONES_TOP && in_bit_i) |=> (flag_o && st_q.ones == '0 && st_q.zeros == '0));

    // R7: flag and data valid never coincide
    p_flag_excl_r7: assert property (@(posedge clk_i) disable iff (srst_i)
        flag_o |-> !out_valid_o);

    // R10: reset clears counters and outputs
    p_reset_rx_r10: assert property (@(posedge clk_i)
        srst_i |=> (!out_valid_o && !flag_o && st_q.ones == '0 && st_q.zeros == '0));

endmodule

// File: rtl/hdlc_transparency_coder.sv
module hdlc_transparency_coder #(
    parameter int ONES_LIMIT  = 5,
    parameter int ZEROS_LIMIT = 7
) (
    input  logic clk_i,
    input  logic srst_i,
    input  logic cfg_bus_mode_i,
    input  logic cfg_one_ins_i,
    input  logic cfg_invert_i,
    input  logic tx_bit_i,
    input  logic tx_valid_i,
    input  logic tx_raw_i,
    output logic tx_ready_o,
    output logic line_tx_o,
    output logic line_tx_valid_o,
    input  logic line_rx_i,
    input  logic line_rx_valid_i,
    output logic rx_bit_o,
    output logic rx_valid_o,
    output logic rx_flag_o
);

    logic one_ins_on;
    logic invert_on;
    logic tx_logic_bit;
    logic rx_logic_bit;

    // mode decode: insertion only in bus mode, inversion never in bus mode
    assign one_ins_on = cfg_one_ins_i && cfg_bus_mode_i;
    assign invert_on  = cfg_invert_i && !cfg_bus_mode_i;

    hdlc_tc_stuffer #(
        .ONES_LIMIT  (ONES_LIMIT),
        .ZEROS_LIMIT (ZEROS_LIMIT)
    ) u_stuffer (
        .clk_i       (clk_i),
        .srst_i      (srst_i),
        .one_ins_i   (one_ins_on),
        .in_bit_i    (tx_bit_i),
        .in_valid_i  (tx_valid_i),
        .in_raw_i    (tx_raw_i),
        .in_ready_o  (tx_ready_o),
        .out_bit_o   (tx_logic_bit),
        .out_valid_o (line_tx_valid_o)
    );

    hdlc_tc_polarity #(.WIDTH(1)) u_tx_pol (
        .bits_i   (tx_logic_bit),
        .invert_i (invert_on),
        .bits_o   (line_tx_o)
    );

    hdlc_tc_polarity #(.WIDTH(1)) u_rx_pol (
        .bits_i   (line_rx_i),
        .invert_i (invert_on),
        .bits_o   (rx_logic_bit)
    );

    hdlc_tc_destuffer #(
        .ONES_LIMIT  (ONES_LIMIT),
        .ZEROS_LIMIT (ZEROS_LIMIT)
    ) u_destuffer (
        .clk_i       (clk_i),
        .srst_i      (srst_i),
        .one_ins_i   (one_ins_on),
        .in_bit_i    (rx_logic_bit),
        .in_valid_i  (line_rx_valid_i),
        .out_bit_o   (rx_bit_o),
        .out_valid_o (rx_valid_o),
        .flag_o      (rx_flag_o)
    );

    // R9: in bus mode the transmit pin carries the logical bit
    p_bus_no_invert_r9: assert property (@(posedge clk_i) disable iff (srst_i)
        (cfg_bus_mode_i && line_tx_valid_o) |-> (line_tx_o == tx_logic_bit));

    // R8: with inversion on outside bus mode the pin is the complement
    p_invert_r8: assert property (@(posedge clk_i) disable iff (srst_i)
        (cfg_invert_i && !cfg_bus_mode_i && line_tx_valid_o) |-> (line_tx_o != tx_logic_bit));

endmodule

// File: tb/hdlc_transparency_coder_tb_top.sv
module hdlc_transparency_coder_tb_top;

    localparam int MAXB = 2048;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic srst = 1'b1;
    logic cfg_bus = 1'b0, cfg_oin = 1'b0, cfg_inv = 1'b0;
    logic tx_bit = 1'b0, tx_valid = 1'b0, tx_raw = 1'b0;
    logic tx_ready, line_tx, line_tx_valid;
    logic loop_en = 1'b0;
    logic drv_rx_bit = 1'b0, drv_rx_valid = 1'b0;
    logic line_rx, line_rx_valid;
    logic rx_bit, rx_valid, rx_flag;

    assign line_rx       = loop_en ? line_tx       : drv_rx_bit;
    assign line_rx_valid = loop_en ? line_tx_valid : drv_rx_valid;

    hdlc_transparency_coder dut_i (
        .clk_i           (clk),
        .srst_i          (srst),
        .cfg_bus_mode_i  (cfg_bus),
        .cfg_one_ins_i   (cfg_oin),
        .cfg_invert_i    (cfg_inv),
        .tx_bit_i        (tx_bit),
        .tx_valid_i      (tx_valid),
        .tx_raw_i        (tx_raw),
        .tx_ready_o      (tx_ready),
        .line_tx_o       (line_tx),
        .line_tx_valid_o (line_tx_valid),
        .line_rx_i       (line_rx),
        .line_rx_valid_i (line_rx_valid),
        .rx_bit_o        (rx_bit),
        .rx_valid_o      (rx_valid),
        .rx_flag_o       (rx_flag)
    );

    int checks = 0, fails = 0, cyc = 0;
    bit pl_bit [MAXB];
    bit pl_raw [MAXB];
    int n_pl;
    bit exp_line [MAXB];
    int exp_n, exp_stalls;
    bit ln_phys [MAXB];
    int ln_n;
    bit rx_cap [MAXB];
    int rx_n, flags, stalls;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            summary();
        end
    end

    // capture, away from the active edge
    always @(negedge clk) begin
        if (line_tx_valid && ln_n < MAXB) begin
            ln_phys[ln_n] = line_tx;
            ln_n++;
        end
        if (rx_valid && rx_n < MAXB) begin
            rx_cap[rx_n] = rx_bit;
            rx_n++;
        end
        if (rx_flag) flags++;
    end

    task automatic clear_cap();
        ln_n = 0; rx_n = 0; flags = 0; stalls = 0;
    endtask

    task automatic do_reset();
        @(negedge clk); srst = 1'b1;
        repeat (2) @(negedge clk);
        srst = 1'b0;
        clear_cap();
    endtask

    // independent model of the transmit stream
    task automatic model_tx(input bit oin_eff);
        int ones = 0, zeros = 0;
        exp_n = 0; exp_stalls = 0;
        for (int i = 0; i < n_pl; i++) begin
            if (ones == 5) begin
                exp_line[exp_n++] = 1'b0; ones = 0; zeros = 1; exp_stalls++;
            end else if (oin_eff && zeros == 7) begin
                exp_line[exp_n++] = 1'b1; zeros = 0; ones = 1; exp_stalls++;
            end
            exp_line[exp_n++] = pl_bit[i];
            if (pl_raw[i]) begin ones = 0; zeros = 0; end
            else if (pl_bit[i]) begin ones = (ones < 5) ? ones + 1 : 5; zeros = 0; end
            else begin zeros = (zeros < 7) ? zeros + 1 : 7; ones = 0; end
        end
        if (ones == 5) exp_line[exp_n++] = 1'b0;
        else if (oin_eff && zeros == 7) exp_line[exp_n++] = 1'b1;
    endtask

    task automatic drive_tx();
        int i = 0;
        while (i < n_pl) begin
            @(negedge clk);
            tx_valid = 1'b1; tx_bit = pl_bit[i]; tx_raw = pl_raw[i];
            #1;
            if (!tx_ready) stalls++;
            if (tx_ready) begin
                @(posedge clk); i++;
            end else begin
                @(posedge clk);
            end
        end
        @(negedge clk); tx_valid = 1'b0; tx_raw = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic drive_rx(input bit b[], input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); drv_rx_bit = b[i]; drv_rx_valid = 1'b1;
        end
        @(negedge clk); drv_rx_valid = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic gen_payload(input int mode, input int n);
        int k = 0;
        n_pl = n;
        while (k < n) begin
            int len;
            bit v;
            case (mode)
                0: begin len = 1; v = 1'($urandom_range(0, 1)); end
                1: begin len = n; v = 1'b0; end
                2: begin len = n; v = 1'b1; end
                default: begin len = $urandom_range(1, 14); v = 1'($urandom_range(0, 1)); end
            endcase
            for (int j = 0; j < len && k < n; j++) begin
                pl_bit[k] = v; pl_raw[k] = 1'b0; k++;
            end
        end
    endtask

    // loopback scenario covering R1, R2, R4, R6, R8, R9
    task automatic t_roundtrip(input bit bus, input bit oin, input bit inv,
                               input int mode, input int n);
        bit oin_eff, inv_eff;
        int run1 = 0, run0 = 0, max1 = 0, max0 = 0, bad = 0;
        cfg_bus = bus; cfg_oin = oin; cfg_inv = inv; loop_en = 1'b1;
        oin_eff = oin && bus; inv_eff = inv && !bus;
        do_reset();
        gen_payload(mode, n);
        model_tx(oin_eff);
        drive_tx();
        chk(ln_n == exp_n, "R4 line bit count", ln_n, exp_n);
        chk(stalls == exp_stalls, "R4 ready stalls", stalls, exp_stalls);
        for (int k = 0; k < exp_n && k < ln_n; k++) begin
            bit lg;
            if (ln_phys[k] !== (exp_line[k] ^ inv_eff)) bad++;
            lg = ln_phys[k] ^ inv_eff;
            if (lg) begin run1++; run0 = 0; end else begin run0++; run1 = 0; end
            if (run1 > max1) max1 = run1;
            if (run0 > max0) max0 = run0;
        end
        chk(bad == 0, inv_eff ? "R8 inverted line bits" : (bus ? "R9 bus line bits" : "R1 line bits"), bad, 0);
        chk(max1 <= 5, "R1 ones run on line", max1, 5);
        if (oin_eff) chk(max0 <= 7, "R2 zeros run on line", max0, 7);
        chk(rx_n == n_pl, "R6 destuffed count", rx_n, n_pl);
        bad = 0;
        for (int k = 0; k < n_pl && k < rx_n; k++) if (rx_cap[k] != pl_bit[k]) bad++;
        chk(bad == 0, "R6 round trip bits", bad, 0);
        chk(flags == 0, "R7 no spurious flag", flags, 0);
        loop_en = 1'b0;
    endtask

    task automatic t_reset_state();
        srst = 1'b1;
        repeat (2) @(negedge clk);
        chk(line_tx_valid == 1'b0, "R10 line valid in reset", line_tx_valid, 0);
        chk(rx_valid == 1'b0, "R10 rx valid in reset", rx_valid, 0);
        chk(rx_flag == 1'b0, "R10 flag in reset", rx_flag, 0);
        chk(tx_ready == 1'b1, "R10 ready in reset", tx_ready, 1);
        srst = 1'b0;
    endtask

    task automatic t_run_carry_r3();
        bit want [13] = '{1,1,1,1,1,0,0,0,0,0,0,0,1};
        int bad = 0;
        cfg_bus = 1; cfg_oin = 1; cfg_inv = 0; loop_en = 0;
        do_reset();
        n_pl = 11;
        for (int i = 0; i < 11; i++) begin pl_bit[i] = (i < 5); pl_raw[i] = 0; end
        drive_tx();
        chk(ln_n == 13, "R3 line length", ln_n, 13);
        for (int k = 0; k < 13 && k < ln_n; k++) if (ln_phys[k] != want[k]) bad++;
        chk(bad == 0, "R3 added bit opens opposite run", bad, 0);
    endtask

    task automatic t_no_insert_r2();
        int ones_seen = 0;
        cfg_bus = 0; cfg_oin = 1; cfg_inv = 0; loop_en = 0;
        do_reset();
        gen_payload(1, 20);
        drive_tx();
        for (int k = 0; k < ln_n; k++) ones_seen += ln_phys[k];
        chk(ln_n == 20, "R2 no insertion outside bus mode, count", ln_n, 20);
        chk(ones_seen == 0, "R2 no insertion outside bus mode, ones", ones_seen, 0);
    endtask

    task automatic t_raw_r5();
        int bad = 0;
        cfg_bus = 0; cfg_oin = 0; cfg_inv = 0; loop_en = 0;
        do_reset();
        n_pl = 10;
        for (int i = 0; i < 10; i++) begin pl_bit[i] = 1; pl_raw[i] = (i == 4); end
        model_tx(1'b0);
        drive_tx();
        chk(ln_n == 11 && exp_n == 11, "R5 raw bit clears runs, count", ln_n, 11);
        for (int k = 0; k < 11 && k < ln_n; k++) if (ln_phys[k] != exp_line[k]) bad++;
        chk(bad == 0 && ln_phys[10] == 1'b0, "R5 raw bit line pattern", bad, 0);
        // a raw flag pattern keeps its six ones
        do_reset();
        n_pl = 8;
        for (int i = 0; i < 8; i++) begin pl_bit[i] = (i != 0 && i != 7); pl_raw[i] = 1; end
        drive_tx();
        chk(ln_n == 8, "R5 raw flag unstuffed", ln_n, 8);
    endtask

    task automatic t_rx_direct();
        bit in1 [10] = '{0,1,1,1,1,1,1,0,1,1};
        bit ex1 [9]  = '{0,1,1,1,1,1,0,1,1};
        bit in2 [7]  = '{1,1,1,1,1,0,1};
        bit in3 [9]  = '{0,0,0,0,0,0,0,1,0};
        int bad = 0;
        cfg_bus = 0; cfg_oin = 0; cfg_inv = 0; loop_en = 0;
        do_reset();
        drive_rx(in1, 10);
        chk(flags == 1, "R7 sixth one flags", flags, 1);
        chk(rx_n == 9, "R7 sixth one not passed", rx_n, 9);
        for (int k = 0; k < 9 && k < rx_n; k++) if (rx_cap[k] != ex1[k]) bad++;
        chk(bad == 0, "R7 counters clear after flag", bad, 0);
        do_reset();
        drive_rx(in2, 7);
        chk(rx_n == 6 && flags == 0, "R6 stuffed zero dropped", rx_n, 6);
        cfg_bus = 1; cfg_oin = 1;
        do_reset();
        drive_rx(in3, 9);
        chk(rx_n == 8, "R6 added one dropped", rx_n, 8);
        bad = 0;
        for (int k = 0; k < rx_n; k++) bad += rx_cap[k];
        chk(bad == 0, "R6 zeros kept after added one", bad, 0);
    endtask

    task automatic t_reset_mid_r10();
        bit r1 [4] = '{1,1,1,1};
        bit r2 [2] = '{1,0};
        cfg_bus = 0; cfg_oin = 0; cfg_inv = 0; loop_en = 0;
        do_reset();
        n_pl = 4;
        for (int i = 0; i < 4; i++) begin pl_bit[i] = 1; pl_raw[i] = 0; end
        drive_tx();
        do_reset();
        n_pl = 2;
        drive_tx();
        chk(ln_n == 2, "R10 tx run does not survive reset", ln_n, 2);
        do_reset();
        drive_rx(r1, 4);
        do_reset();
        drive_rx(r2, 2);
        chk(rx_n == 2, "R10 rx run does not survive reset", rx_n, 2);
    endtask

    initial begin
        clear_cap();
        t_reset_state();
        t_roundtrip(0, 0, 0, 0, 400);
        t_roundtrip(0, 0, 0, 2, 120);
        t_roundtrip(1, 1, 0, 1, 120);
        t_roundtrip(1, 1, 0, 3, 500);
        t_roundtrip(0, 0, 1, 3, 300);
        t_roundtrip(1, 1, 1, 3, 300);
        t_roundtrip(1, 0, 0, 1, 60);
        t_run_carry_r3();
        t_no_insert_r2();
        t_raw_r5();
        t_rx_direct();
        t_reset_mid_r10();
        summary();
    end

endmodule